// File: doc/BRIEF.md
# Receive sync bit pulse generator

This block drives one output line that tells the system two things about the receive side of a line transceiver. First, it shows whether the receiver has locked onto the frame structure. Second, once the receiver is locked, it shows where the sync bit falls in time within each received frame. The receiver decodes the line, recovers the clock and searches for the sync pattern outside this block. That logic supplies a lock flag, a tick that marks each line bit, and a strobe that marks the sync bit slot.

In network mode the output stays high while the receiver is unlocked. After lock it idles low and rises for one line bit period each time the sync slot strobe arrives. In transparent modem mode the output is held low and ignores all other inputs. The `bit_en` tick always runs at the fast line rate. At the slow rate one line bit spans two ticks, so the pulse lasts two ticks at the slow rate and one tick at the fast rate. A status bit mirrors the synchronized state.

Top module: `rxsync_pulse_gen`

## Requirements
- R1: While `rst_n` is low, at the first clock edge `sync_pulse_o` is 1 and `sync_stat_o` is 0, and no pulse is pending afterwards.
- R2: With `mode_sel`=0 (network) and `lock_i`=0, `sync_pulse_o` is 1 and `sync_stat_o` is 0 from the clock edge after those inputs are applied.
- R3: With `mode_sel`=0 and `lock_i`=1 and no pulse in progress, `sync_pulse_o` is 0.
- R4: In network mode with lock, a clock in which `bit_en` and `slot_stb` are both 1 makes `sync_pulse_o` 1 from the next clock edge.
- R5: With `rate_sel`=1 (fast line rate), the pulse falls at the clock edge of the next cycle that has `bit_en`=1, so it lasts one tick.
- R6: With `rate_sel`=0 (slow line rate), the pulse falls at the edge of the second `bit_en` cycle after the strobe, so it lasts two ticks.
- R7: A `slot_stb` in a cycle with `bit_en`=0 is ignored, and `sync_pulse_o` stays 0.
- R8: If `lock_i` drops during a pulse, `sync_pulse_o` is 1 at the next edge. When lock returns, no part of the interrupted pulse remains, so the output is 0.
- R9: With `mode_sel`=1 (modem), `sync_pulse_o` and `sync_stat_o` are 0 from the next edge whatever the lock, tick and strobe inputs do.
- R10: `sync_stat_o` is 1 exactly when the previous cycle had `mode_sel`=0 and `lock_i`=1.
- R11: A strobe tick that arrives during a pulse restarts the full pulse length from that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line bit tick at the fast line rate |
| rate_sel | input | 1 | 1 = fast line rate, 0 = slow line rate |
| mode_sel | input | 1 | 0 = network mode, 1 = transparent modem mode |
| lock_i | input | 1 | Receiver frame lock flag |
| slot_stb | input | 1 | Marks the sync bit slot, qualified by `bit_en` |
| sync_pulse_o | output | 1 | Sync indication and sync bit pulse |
| sync_stat_o | output | 1 | Synchronized status bit |

## Verification
The bench places strobes with and without a tick. A design that ignores the tick qualification raises a pulse on the untimed strobe. It measures pulse length at both rates. A design with a miscounted tick would make the pulse one tick too long or too short, or ignore the rate setting. It drops lock in the middle of a slow pulse and then restores it. A design that keeps its counter through the loss would show a stale pulse remnant after relock. It also retriggers a pulse and switches into modem mode while strobes continue. A wrong design there either ends the pulse early or leaks pulses and status onto a line that should stay low.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
    typedef enum logic {
        LINE_SLOW = 1'b0,
        LINE_FAST = 1'b1
    } line_rate_e;

    typedef enum logic {
        OP_NETWORK = 1'b0,
        OP_MODEM   = 1'b1
    } op_mode_e;

    function automatic int unsigned max_ticks(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/rsp_pulse_timer.sv
module rsp_pulse_timer
    import rsp_pkg::*;
#(
    parameter int unsigned TICKS_FAST = 1,
    parameter int unsigned TICKS_SLOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bit_en,
    input  logic slot_stb,
    input  logic rate_sel,
    output logic pulse_next
);
    localparam int unsigned MAXT = max_ticks(TICKS_FAST, TICKS_SLOW);
    localparam int unsigned CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] LEN_FAST = CW'(TICKS_FAST);
    localparam logic [CW-1:0] LEN_SLOW = CW'(TICKS_SLOW);

    typedef struct packed {
        logic [CW-1:0] remain;
    } timer_t;

    timer_t st_d, st_q;
    line_rate_e rate;

    assign rate = line_rate_e'(rate_sel);

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.remain = '0;
        end else if (bit_en && slot_stb) begin
            st_d.remain = (rate == LINE_FAST) ? LEN_FAST : LEN_SLOW;
        end else if (bit_en && st_q.remain != '0) begin
            st_d.remain = st_q.remain - 1'b1;
        end
    end

    assign pulse_next = (st_d.remain != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.remain <= CW'(MAXT));
    assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bit_en && slot_stb) |=> (st_q.remain != '0));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.remain == '0));
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bit_en) |=> $stable(st_q.remain));
endmodule

// File: rtl/rsp_line_flag.sv
module rsp_line_flag
    import rsp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sel,
    input  logic lock_i,
    input  logic pulse_next,
    output logic line_o,
    output logic stat_o
);
    typedef struct packed {
        logic line;
        logic stat;
    } flag_t;

    flag_t fl_d, fl_q;
    op_mode_e mode;

    assign mode = op_mode_e'(mode_sel);

    always_comb begin
        fl_d = fl_q;
        if (mode == OP_MODEM) begin
            fl_d.line = 1'b0;
            fl_d.stat = 1'b0;
        end else if (!lock_i) begin
            fl_d.line = 1'b1;
            fl_d.stat = 1'b0;
        end else begin
            fl_d.line = pulse_next;
            fl_d.stat = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '{line: 1'b1, stat: 1'b0};
        else        fl_q <= fl_d;
    end

    assign line_o = fl_q.line;
    assign stat_o = fl_q.stat;

    assert_modem_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel |=> (!line_o && !stat_o));
    assert_unlock_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel && !lock_i) |=> (line_o && !stat_o));
    assert_stat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel && lock_i) |=> stat_o);
endmodule

// File: rtl/rxsync_pulse_gen.sv
module rxsync_pulse_gen
    import rsp_pkg::*;
#(
    parameter int unsigned TICKS_FAST = 1,
    parameter int unsigned TICKS_SLOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rate_sel,
    input  logic mode_sel,
    input  logic lock_i,
    input  logic slot_stb,
    output logic sync_pulse_o,
    output logic sync_stat_o
);
    logic run;
    logic pulse_next;

    assign run = lock_i && (op_mode_e'(mode_sel) == OP_NETWORK);

    rsp_pulse_timer #(
        .TICKS_FAST(TICKS_FAST),
        .TICKS_SLOW(TICKS_SLOW)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .bit_en    (bit_en),
        .slot_stb  (slot_stb),
        .rate_sel  (rate_sel),
        .pulse_next(pulse_next)
    );

    rsp_line_flag i_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .lock_i    (lock_i),
        .pulse_next(pulse_next),
        .line_o    (sync_pulse_o),
        .stat_o    (sync_stat_o)
    );

    assert_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bit_en && slot_stb) |=> sync_pulse_o);
    assert_untimed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bit_en && !sync_pulse_o) |=> !sync_pulse_o);
endmodule

// File: tb/test_rxsync_pulse_gen.sv
module test_rxsync_pulse_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, rate_sel = 1'b1, mode_sel = 1'b0, lock_i = 1'b0, slot_stb = 1'b0;
    logic sync_pulse_o, sync_stat_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic m_out = 1'b1, m_stat = 1'b0;
    int   m_rem = 0;

    always #4 clk = ~clk;

    rxsync_pulse_gen i_rxsync_pulse_gen (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rate_sel(rate_sel),
        .mode_sel(mode_sel), .lock_i(lock_i), .slot_stb(slot_stb),
        .sync_pulse_o(sync_pulse_o), .sync_stat_o(sync_stat_o)
    );

    // Behavioural reference: remaining ticks of the current pulse
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rem = 0; m_out = 1'b1; m_stat = 1'b0;
        end else if (mode_sel) begin
            m_rem = 0; m_out = 1'b0; m_stat = 1'b0;
        end else if (!lock_i) begin
            m_rem = 0; m_out = 1'b1; m_stat = 1'b0;
        end else begin
            if (bit_en && slot_stb) m_rem = rate_sel ? 1 : 2;
            else if (bit_en && m_rem > 0) m_rem = m_rem - 1;
            m_out = (m_rem > 0);
            m_stat = 1'b1;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("R2 R3 R4 R5 R6 R8 R9 R10 R11 model pulse", sync_pulse_o, m_out);
            chk("R10 model status", sync_stat_o, m_stat);
        end
    end

    task automatic step(input logic en, input logic st);
        @(negedge clk);
        bit_en = en; slot_stb = st;
        @(posedge clk); #1;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(0, 0); step(0, 0);
        chk("R1 reset pulse", sync_pulse_o, 1'b1);
        chk("R1 reset status", sync_stat_o, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        step(1, 1);
        chk("R2 unlocked high", sync_pulse_o, 1'b1);
        chk("R2 unlocked status", sync_stat_o, 1'b0);
        @(negedge clk); lock_i = 1'b1; rate_sel = 1'b1;
        step(0, 0); step(1, 0);
        chk("R3 locked idle low", sync_pulse_o, 1'b0);
        chk("R10 locked status", sync_stat_o, 1'b1);
        step(1, 1);
        chk("R4 pulse rise", sync_pulse_o, 1'b1);
        step(0, 0);
        chk("R5 held between ticks", sync_pulse_o, 1'b1);
        step(1, 0);
        chk("R5 fast fall on next tick", sync_pulse_o, 1'b0);
        @(negedge clk); rate_sel = 1'b0;
        step(1, 1);
        chk("R6 slow rise", sync_pulse_o, 1'b1);
        step(1, 0);
        chk("R6 slow after one tick", sync_pulse_o, 1'b1);
        step(1, 0);
        chk("R6 slow fall after two ticks", sync_pulse_o, 1'b0);
        step(0, 1);
        chk("R7 untimed strobe ignored", sync_pulse_o, 1'b0);
        step(0, 0);
        chk("R7 still low", sync_pulse_o, 1'b0);
        step(1, 1); step(1, 0); step(1, 1);
        chk("R11 retrigger high", sync_pulse_o, 1'b1);
        step(1, 0);
        chk("R11 still high one tick after retrigger", sync_pulse_o, 1'b1);
        step(1, 0);
        chk("R11 fall two ticks after retrigger", sync_pulse_o, 1'b0);
        step(1, 1);
        @(negedge clk); lock_i = 1'b0;
        step(0, 0);
        chk("R8 lock loss high", sync_pulse_o, 1'b1);
        chk("R8 lock loss status", sync_stat_o, 1'b0);
        @(negedge clk); lock_i = 1'b1;
        step(0, 0);
        chk("R8 no stale pulse after relock", sync_pulse_o, 1'b0);
        @(negedge clk); mode_sel = 1'b1;
        step(1, 1);
        chk("R9 modem low", sync_pulse_o, 1'b0);
        chk("R9 modem status", sync_stat_o, 1'b0);
        @(negedge clk); lock_i = 1'b0;
        step(1, 1);
        chk("R9 modem low unlocked", sync_pulse_o, 1'b0);
        @(negedge clk); mode_sel = 1'b0; lock_i = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            bit_en   = ($urandom_range(0, 2) != 0);
            slot_stb = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 60) == 0) lock_i = ~lock_i;
            if ($urandom_range(0, 150) == 0) rate_sel = ~rate_sel;
            if ($urandom_range(0, 200) == 0) mode_sel = ~mode_sel;
            if ($urandom_range(0, 700) == 0) rst_n = 1'b0;
            else rst_n = 1'b1;
        end
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule